// File: doc/BRIEF.md
# Branch History Table Predictor

This block is a small direct-mapped table of recently resolved branches. It sits beside the fetch stage. Each cycle it takes the fetch address and, in the same cycle, says whether that address is a known branch, whether the branch is expected to be taken, and where it goes. It also returns the address that fetch should use next. When the table has no matching entry, fetch falls back to predict-not-taken and continues at the next sequential instruction.

Each entry holds a tag taken from the upper address bits, a two-bit saturating outcome counter and the branch target. Low-order word-address bits select the entry. A separate update port takes resolved branches from the back of the pipeline and writes on the clock edge. On a tag hit the update moves the counter by one step. On a tag miss it replaces the entry with a fresh one in the weak state that matches the actual outcome. Because the counter has hysteresis, one surprise does not flip a strong prediction. A repeated loop branch is therefore mispredicted only at its exit, not again on re-entry.

Top module: `bht_predictor`

## Requirements
- R1: After reset no entry is valid, so every lookup reports a miss.
- R2: On a lookup miss, lk_hit, lk_taken and lk_target are all zero, and lk_next_pc equals lk_pc + 4.
- R3: An update whose address misses in the table allocates the entry. The counter starts at 10 (weak taken) if the outcome was taken and at 01 (weak not-taken) otherwise, and the target is stored. A lookup of that address in the next cycle hits.
- R4: The counter encoding is 00 strong not-taken, 01 weak not-taken, 10 weak taken and 11 strong taken. The prediction is counter bit 1. A hitting update adds one for taken and subtracts one for not-taken, and it saturates at 11 and at 00.
- R5: From a strong state, one disagreeing outcome does not change the prediction. A second consecutive disagreement does.
- R6: A lookup whose address selects an occupied entry but carries a different tag misses. An update with a different tag replaces the old branch.
- R7: The lookup is combinational. An update to the entry being looked up in the same cycle is not visible until the next cycle.
- R8: A loop branch taken four times and then not taken, run repeatedly, is predicted taken on every iteration of the second pass. It is therefore mispredicted only at the exit, and it is again predicted taken on re-entry.
- R9: On a hit predicted taken, lk_next_pc equals the stored target. On a hit predicted not-taken, it equals lk_pc + 4.
- R10: The entry index is address bits [5:2] for the default 16 entries and 4-byte instructions. Branches at different indices do not disturb each other.
- R11: The stored target is rewritten by a taken update or by an allocation. A not-taken update to a hitting entry keeps the previous target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | 32 | Fetch address to look up |
| lk_hit | output | 1 | A valid entry with a matching tag exists |
| lk_taken | output | 1 | Hit and predicted taken |
| lk_target | output | 32 | Stored target on a hit, zero otherwise |
| lk_next_pc | output | 32 | Address fetch should use next |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome |
| up_target | input | 32 | Actual target |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 16 entries and 4-byte instructions. With these values, two addresses that differ only above bit 5 share an entry. This makes tag aliasing and replacement reachable with a handful of fixed addresses. One entry is driven through every counter state, including both saturation ends. A four-iteration loop branch is then run across three passes, which exposes the first-pass cold miss, the single exit mispredict and the re-entry prediction. Same-cycle lookup and update of one entry show that the read returns the old contents.

// File: rtl/bht_pkg.sv
package bht_pkg;

   typedef enum logic [1:0] {
      CTR_SNT = 2'b00,
      CTR_WNT = 2'b01,
      CTR_WT  = 2'b10,
      CTR_ST  = 2'b11
   } ctr_e;

   function automatic ctr_e ctr_fresh(input logic taken);
      return taken ? CTR_WT : CTR_WNT;
   endfunction

endpackage

// File: rtl/bht_ctr_step.sv
module bht_ctr_step
   import bht_pkg::*;
(
   input  ctr_e cur,
   input  logic taken,
   output ctr_e nxt
);

   always_comb begin
      if (taken)
         nxt = (cur == CTR_ST)  ? CTR_ST  : ctr_e'(cur + 2'd1);
      else
         nxt = (cur == CTR_SNT) ? CTR_SNT : ctr_e'(cur - 2'd1);
   end

   always_comb begin
      // R5
      if (cur == CTR_ST && !taken)
         st_decay_chk: assert (nxt == CTR_WT);
      // R4
      if (cur == CTR_SNT && !taken)
         floor_sat_chk: assert (nxt == CTR_SNT);
   end

endmodule

// File: rtl/bht_store.sv
module bht_store
   import bht_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int TAG_W   = 26,
   parameter int TGT_W   = 32,
   localparam int IDX_W  = $clog2(ENTRIES)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] a_idx,
   output logic             a_valid,
   output logic [TAG_W-1:0] a_tag,
   output ctr_e             a_ctr,
   output logic [TGT_W-1:0] a_tgt,
   input  logic [IDX_W-1:0] b_idx,
   output logic             b_valid,
   output logic [TAG_W-1:0] b_tag,
   output ctr_e             b_ctr,
   output logic [TGT_W-1:0] b_tgt,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  ctr_e             wr_ctr,
   input  logic [TGT_W-1:0] wr_tgt
);

   logic [ENTRIES-1:0] valid_q;
   logic [TAG_W-1:0]   tag_q [ENTRIES];
   ctr_e               ctr_q [ENTRIES];
   logic [TGT_W-1:0]   tgt_q [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         valid_q <= '0;
      else if (wr_en)
         valid_q[wr_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         tag_q[wr_idx] <= wr_tag;
         ctr_q[wr_idx] <= wr_ctr;
         tgt_q[wr_idx] <= wr_tgt;
      end
   end

   assign a_valid = valid_q[a_idx];
   assign a_tag   = tag_q[a_idx];
   assign a_ctr   = ctr_q[a_idx];
   assign a_tgt   = tgt_q[a_idx];
   assign b_valid = valid_q[b_idx];
   assign b_tag   = tag_q[b_idx];
   assign b_ctr   = ctr_q[b_idx];
   assign b_tgt   = tgt_q[b_idx];

   // R1
   clear_on_reset_chk: assert property (@(posedge clk) $rose(rst_n) |-> valid_q == '0);

endmodule

// File: rtl/bht_predictor.sv
module bht_predictor
   import bht_pkg::*;
#(
   parameter int PC_W       = 32,
   parameter int ENTRIES    = 16,
   parameter int ALIGN_BITS = 2
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] lk_pc,
   output logic            lk_hit,
   output logic            lk_taken,
   output logic [PC_W-1:0] lk_target,
   output logic [PC_W-1:0] lk_next_pc,
   input  logic            up_valid,
   input  logic [PC_W-1:0] up_pc,
   input  logic            up_taken,
   input  logic [PC_W-1:0] up_target
);

   localparam int IDX_W      = $clog2(ENTRIES);
   localparam int TAG_W      = PC_W - IDX_W - ALIGN_BITS;
   localparam int INSN_BYTES = 1 << ALIGN_BITS;

   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("bht_predictor: ENTRIES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("bht_predictor: address too narrow for index and alignment");
   end

   logic [IDX_W-1:0] lk_idx, up_idx;
   logic [TAG_W-1:0] lk_tagv, up_tagv;
   assign lk_idx  = lk_pc[ALIGN_BITS +: IDX_W];
   assign lk_tagv = lk_pc[PC_W-1 -: TAG_W];
   assign up_idx  = up_pc[ALIGN_BITS +: IDX_W];
   assign up_tagv = up_pc[PC_W-1 -: TAG_W];

   logic             a_valid, b_valid;
   logic [TAG_W-1:0] a_tag, b_tag;
   ctr_e             a_ctr, b_ctr, step_ctr, wr_ctr;
   logic [PC_W-1:0]  a_tgt, b_tgt, wr_tgt;

   bht_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .TGT_W(PC_W)) store_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .a_idx   (lk_idx),
      .a_valid (a_valid),
      .a_tag   (a_tag),
      .a_ctr   (a_ctr),
      .a_tgt   (a_tgt),
      .b_idx   (up_idx),
      .b_valid (b_valid),
      .b_tag   (b_tag),
      .b_ctr   (b_ctr),
      .b_tgt   (b_tgt),
      .wr_en   (up_valid),
      .wr_idx  (up_idx),
      .wr_tag  (up_tagv),
      .wr_ctr  (wr_ctr),
      .wr_tgt  (wr_tgt)
   );

   // lookup side
   always_comb begin
      lk_hit     = a_valid && (a_tag == lk_tagv);
      lk_taken   = lk_hit && a_ctr[1];
      lk_target  = lk_hit ? a_tgt : '0;
      lk_next_pc = lk_taken ? a_tgt : lk_pc + PC_W'(INSN_BYTES);
   end

   // update side
   logic up_hit;
   assign up_hit = b_valid && (b_tag == up_tagv);

   bht_ctr_step step_i (
      .cur   (b_ctr),
      .taken (up_taken),
      .nxt   (step_ctr)
   );

   always_comb begin
      wr_ctr = up_hit ? step_ctr : ctr_fresh(up_taken);
      wr_tgt = (!up_hit || up_taken) ? up_target : b_tgt;
   end

   // R2
   miss_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_next_pc == lk_pc + PC_W'(INSN_BYTES)) && !lk_taken);

   // R3
   alloc_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(up_valid) && lk_pc == $past(up_pc)) |-> lk_hit);

   // R11
   tgt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(up_valid && up_taken) && lk_pc == $past(up_pc)) |-> lk_target == $past(up_target));

   // R7
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(up_valid) && $stable(lk_pc)) |->
         ($stable(lk_hit) && $stable(lk_taken) && $stable(lk_target)));

   // R10
   align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      up_valid |-> up_pc[ALIGN_BITS-1:0] == '0);

endmodule

// File: tb/bht_predictor_tb_top.sv
module bht_predictor_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lk_pc = '0;
   logic        lk_hit, lk_taken;
   logic [31:0] lk_target, lk_next_pc;
   logic        up_valid = 1'b0;
   logic [31:0] up_pc = '0;
   logic        up_taken = 1'b0;
   logic [31:0] up_target = '0;

   always #2 clk = ~clk;

   bht_predictor dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_pc      (lk_pc),
      .lk_hit     (lk_hit),
      .lk_taken   (lk_taken),
      .lk_target  (lk_target),
      .lk_next_pc (lk_next_pc),
      .up_valid   (up_valid),
      .up_pc      (up_pc),
      .up_taken   (up_taken),
      .up_target  (up_target)
   );

   typedef struct {
      bit          hit;
      bit          tkn;
      logic [31:0] nxt;
      string       req;
   } exp_t;

   exp_t exp_q[$];
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done  = 0;

   localparam logic [31:0] PA = 32'h0000_1008;
   localparam logic [31:0] PB = 32'h0000_2008;
   localparam logic [31:0] PC = 32'h0000_1010;
   localparam logic [31:0] PD = 32'h0000_3000;
   localparam logic [31:0] TA = 32'h0000_0400;
   localparam logic [31:0] TB = 32'h0000_0800;
   localparam logic [31:0] TC = 32'h0000_0C00;
   localparam logic [31:0] TD = 32'h0000_2F00;

   // driver: one cycle of stimulus, optional expected lookup result
   task automatic step(input bit uv, input logic [31:0] upc, input bit ut,
                       input logic [31:0] utg, input logic [31:0] lpc,
                       input bit chk, input bit eh, input bit et,
                       input logic [31:0] en, input string req);
      @(posedge clk);
      #1;
      up_valid  = uv;
      up_pc     = upc;
      up_taken  = ut;
      up_target = utg;
      lk_pc     = lpc;
      if (chk) begin
         exp_t e;
         e.hit = eh; e.tkn = et; e.nxt = en; e.req = req;
         exp_q.push_back(e);
      end
   endtask

   // monitor: compare away from the active edge
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         n_cmp++;
         if (lk_hit !== e.hit || lk_taken !== e.tkn || lk_next_pc !== e.nxt) begin
            n_bad++;
            $display("FAIL %s: got hit=%b taken=%b next=%h, expected hit=%b taken=%b next=%h",
                     e.req, lk_hit, lk_taken, lk_next_pc, e.hit, e.tkn, e.nxt);
         end
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      step(0, 0, 0, 0, PA, 1, 0, 0, PA + 4, "R1");
      step(0, 0, 0, 0, PC, 1, 0, 0, PC + 4, "R1");
      // R7 same-cycle update invisible; then R3 R9 allocation taken
      step(1, PA, 1, TA, PA, 1, 0, 0, PA + 4, "R7");
      step(0, 0, 0, 0, PA, 1, 1, 1, TA, "R3 R9");
      step(1, PA, 0, TA, PA, 1, 1, 1, TA, "R7");
      // R4 counter walk
      step(0, 0, 0, 0, PA, 1, 1, 0, PA + 4, "R4 R9");
      step(1, PA, 1, TA, PA, 1, 1, 0, PA + 4, "R4");
      step(1, PA, 1, TA, PA, 1, 1, 1, TA, "R4");
      step(1, PA, 1, TA, PA, 1, 1, 1, TA, "R4");
      // R5 hysteresis from strong taken
      step(1, PA, 0, TA, PA, 1, 1, 1, TA, "R5");
      step(0, 0, 0, 0, PA, 1, 1, 1, TA, "R5");
      step(1, PA, 0, TA, PA, 1, 1, 1, TA, "R5");
      step(0, 0, 0, 0, PA, 1, 1, 0, PA + 4, "R5");
      // R4 floor saturation
      step(1, PA, 0, TA, PA, 1, 1, 0, PA + 4, "R4");
      step(1, PA, 0, TA, PA, 1, 1, 0, PA + 4, "R4");
      step(1, PA, 1, TA, PA, 1, 1, 0, PA + 4, "R4");
      step(0, 0, 0, 0, PA, 1, 1, 0, PA + 4, "R4");
      // R11 target rules
      step(1, PA, 1, TB, PA, 1, 1, 0, PA + 4, "R11");
      step(1, PA, 1, TB, PA, 1, 1, 1, TB, "R11");
      step(1, PA, 0, 32'hDEAD_0000, PA, 1, 1, 1, TB, "R11");
      step(0, 0, 0, 0, PA, 1, 1, 1, TB, "R11");
      // R6 aliasing tag, R2 miss fallback
      step(0, 0, 0, 0, PB, 1, 0, 0, PB + 4, "R2 R6");
      step(1, PB, 0, TC, PB, 1, 0, 0, PB + 4, "R6");
      step(0, 0, 0, 0, PB, 1, 1, 0, PB + 4, "R3");
      step(0, 0, 0, 0, PA, 1, 0, 0, PA + 4, "R6");
      // R10 independent indices
      step(1, PC, 1, TC, PC, 1, 0, 0, PC + 4, "R10");
      step(0, 0, 0, 0, PC, 1, 1, 1, TC, "R10");
      step(0, 0, 0, 0, PB, 1, 1, 0, PB + 4, "R10");
      // R8 loop: pass 1 warms up
      for (int i = 0; i < 4; i++) step(1, PD, 1, TD, PD, 0, 0, 0, 0, "R8");
      step(1, PD, 0, TD, PD, 0, 0, 0, 0, "R8");
      // pass 2: all predicted taken, only exit wrong
      for (int i = 0; i < 4; i++) step(1, PD, 1, TD, PD, 1, 1, 1, TD, "R8");
      step(1, PD, 0, TD, PD, 1, 1, 1, TD, "R8");
      // pass 3 re-entry still predicted taken
      step(1, PD, 1, TD, PD, 1, 1, 1, TD, "R8");
      step(0, 0, 0, 0, PD, 1, 1, 1, TD, "R8");
      step(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
      @(posedge clk);
      @(posedge clk);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule